// File: doc/BRIEF.md
# ECC-Corrected Wide ROM Fetch

This block is the read path of a byte-addressed ROM that stores its contents as wide protected codewords. One read fetches a full 38-bit codeword, which holds 32 data bits and 6 check bits. The block computes the Hamming syndrome, repairs a single flipped bit, and splits the repaired word into four byte lanes. The two low address bits then pick which lane appears on the 8-bit output. Two flags come out with every result: one says a bit was repaired, and the other says the syndrome pointed at no valid bit position.

The storage array is interleaved. Each physical row holds several codewords, and a given codeword bit of neighbouring codewords sits in neighbouring columns. Because of this, a defect that spans two adjacent columns damages two different codewords once each, and each of them can still be repaired. The image is computed at elaboration from a fixed fill rule, with a small set of built-in defects placed by parameters so that every repair path can be observed. A full-size array uses 15 codeword address bits, which gives 32K codewords and 128K bytes. The default build is smaller.

Top module: `ecc_rom_fetch`

## Requirements
- R1: A read presented with `rd_en` high at clock edge k gives `out_valid` high after edge k+1, carrying that read's result. `out_valid` is low in every cycle that follows an edge with no read. Reads may be issued on every cycle.
- R2: While `rst_n` is low at a clock edge, `out_valid`, `out_byte`, `out_fixed` and `out_uncorr` are all driven to 0.
- R3: `rd_addr[1:0]` = n selects bits [8n+7:8n] of the 32-bit word, and `rd_addr[ADDR_W-1:2]` is the codeword index w. The stored word for w is ((w+1) * 0x9E3779B1) mod 2^32.
- R4: A codeword occupies positions 1..38. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bit i sits at the i-th remaining position in ascending order. The syndrome is the XOR of the positions of all set bits. A zero syndrome gives the stored data with both flags at 0.
- R5: A syndrome in the range 1..38 inverts that position, whether it holds a data bit or a check bit, and reports `out_fixed`=1 and `out_uncorr`=0.
- R6: A syndrome in the range 39..63 reports `out_uncorr`=1 and `out_fixed`=0, and the data passes through without any repair.
- R7: Physical row r holds codewords r*4+j for slots j=0..3. Position p of slot j is stored in column (p-1)*4+j. A defect on two adjacent columns is therefore repaired as two independent single errors in two codewords.
- R8: The default built-in defects are placed as follows. Row 3 has columns 10 and 11 inverted, which puts data bit 0 in error in codewords 14 and 15, and both are repaired. Row 5 has column 0 inverted, which puts check position 1 in error in codeword 20, and it is repaired. Slot 2 of row 7 has positions 7 and 32 inverted, so codeword 30 is uncorrectable and returns its word with data bit 3 inverted.
- R9: In a cycle where `out_valid` is low, `out_byte` keeps its previous value and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W (8) | Byte address: codeword index above, lane in [1:0] |
| out_valid | output | 1 | Result (data and syndrome flags) valid |
| out_byte | output | 8 | Selected byte lane of the repaired word |
| out_fixed | output | 1 | A single bit was repaired |
| out_uncorr | output | 1 | Syndrome pointed outside positions 1..38 |

## Verification
A wrong row or slot latched in the first stage shows up as a wrong byte on the same output cycle that carries that read. In most cases the flags are wrong too, because the fault codewords are placed at known indices. A fault in the syndrome or repair logic shows on the codewords with built-in defects: the byte of codeword 14 or 15 comes out wrong, or the flags of codewords 20 and 30 are swapped or missing, two cycles after the request. A slip in the valid pipeline breaks the one-to-one pairing of requests and results within a cycle.

// File: rtl/ecc_rom_pkg.sv
// Shared constants, types and code-construction functions for the ECC ROM
// fetch path. Assumes a 38-bit Hamming layout with check bits at
// power-of-two positions (1-based).
package ecc_rom_pkg;
    localparam int DATA_W  = 32;
    localparam int CHECK_W = 6;
    localparam int CODE_W  = DATA_W + CHECK_W;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;
    localparam logic [31:0] FILL_MULT = 32'h9E37_79B1;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [CHECK_W-1:0] synd_t;

    // True when a 1-based position is a check-bit position.
    function automatic bit is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // 1-based codeword position of data bit i.
    function automatic int data_pos(int i);
        int seen;
        int result;
        seen   = 0;
        result = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_pow2(p)) begin
                if (seen == i) result = p;
                seen++;
            end
        end
        return result;
    endfunction

    // Stored word for codeword index w.
    function automatic word_t word_image(int w);
        logic [31:0] n;
        n = 32'(w) + 32'd1;
        return n * FILL_MULT;
    endfunction

    // Hamming encoder, used only to build the ROM image.
    function automatic code_t encode(word_t d);
        code_t cw;
        logic  par;
        cw = '0;
        for (int i = 0; i < DATA_W; i++) cw[data_pos(i)-1] = d[i];
        for (int c = 0; c < CHECK_W; c++) begin
            par = 1'b0;
            for (int p = 1; p <= CODE_W; p++)
                if (((p >> c) & 1) == 1 && !is_pow2(p)) par = par ^ cw[p-1];
            cw[(1 << c) - 1] = par;
        end
        return cw;
    endfunction
endpackage

// File: rtl/ecc_rom_store.sv
// Interleaved ROM array with a registered read port.
// Each row holds SLOTS codewords. Position p of slot j sits in column
// (p-1)*SLOTS + j. Built-in defects are applied by parameters.
// Assumes the defect columns lie inside the row.
module ecc_rom_store
    import ecc_rom_pkg::*;
#(
    parameter int ROW_AW    = 4,
    parameter int SLOTS     = 4,
    parameter int PAIR_ROW  = 3,
    parameter int PAIR_COL  = 10,
    parameter int SGL_ROW   = 5,
    parameter int SGL_COL   = 0,
    parameter int DBL_ROW   = 7,
    parameter int DBL_SLOT  = 2,
    parameter int DBL_POS_A = 7,
    parameter int DBL_POS_B = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en_i,
    input  logic [ROW_AW-1:0]        row_i,
    output logic [CODE_W*SLOTS-1:0]  row_o
);
    localparam int ROWS  = 1 << ROW_AW;
    localparam int ROW_W = CODE_W * SLOTS;

    logic [ROW_W-1:0] image [ROWS];

    // Physical row r: interleaved codewords plus any built-in defects.
    function automatic logic [ROW_W-1:0] build_row(int r);
        logic [ROW_W-1:0] bits;
        code_t            cw;
        int               ca;
        int               cb;
        bits = '0;
        for (int j = 0; j < SLOTS; j++) begin
            cw = encode(word_image(r * SLOTS + j));
            for (int k = 0; k < CODE_W; k++) bits[k*SLOTS + j] = cw[k];
        end
        if (r == PAIR_ROW) begin
            bits[PAIR_COL]     = ~bits[PAIR_COL];
            bits[PAIR_COL + 1] = ~bits[PAIR_COL + 1];
        end
        if (r == SGL_ROW) bits[SGL_COL] = ~bits[SGL_COL];
        if (r == DBL_ROW) begin
            ca = (DBL_POS_A - 1) * SLOTS + DBL_SLOT;
            cb = (DBL_POS_B - 1) * SLOTS + DBL_SLOT;
            bits[ca] = ~bits[ca];
            bits[cb] = ~bits[cb];
        end
        return bits;
    endfunction

    // Fill the ROM image at elaboration.
    initial begin
        for (int r = 0; r < ROWS; r++) image[r] = build_row(r);
    end

    // Registered row read.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_o <= '0;
        else if (rd_en_i) row_o <= image[row_i];
    end
endmodule

// File: rtl/ecc_cw_unscatter.sv
// Undoes the column interleave: picks one slot's 38 bits from a physical row.
// Purely combinational.
module ecc_cw_unscatter
    import ecc_rom_pkg::*;
#(
    parameter int SLOT_AW = 2,
    localparam int SLOTS  = 1 << SLOT_AW
) (
    input  logic [CODE_W*SLOTS-1:0] row_i,
    input  logic [SLOT_AW-1:0]      slot_i,
    output code_t                   cw_o
);
    code_t per_slot [SLOTS];

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        for (genvar k = 0; k < CODE_W; k++) begin : g_bit
            assign per_slot[j][k] = row_i[k*SLOTS + j];
        end
    end

    assign cw_o = per_slot[slot_i];
endmodule

// File: rtl/ecc_hamming_fix.sv
// Syndrome decode and single-bit repair for a 38-bit codeword.
// In-range syndrome: flip that position. Out-of-range: pass raw data and flag.
module ecc_hamming_fix
    import ecc_rom_pkg::*;
(
    input  code_t cw_i,
    output word_t data_o,
    output logic  fixed_o,
    output logic  uncorr_o
);
    synd_t syn;
    code_t rep_cw;

    // Syndrome: XOR of positions of all set bits.
    always_comb begin
        syn = '0;
        for (int p = 1; p <= CODE_W; p++)
            if (cw_i[p-1]) syn = syn ^ synd_t'(p);
    end

    // Repair the addressed position when it lies inside the codeword.
    always_comb begin
        rep_cw   = cw_i;
        fixed_o  = 1'b0;
        uncorr_o = (syn != '0);
        for (int p = 1; p <= CODE_W; p++) begin
            if (int'(syn) == p) begin
                rep_cw[p-1] = ~cw_i[p-1];
                fixed_o     = 1'b1;
                uncorr_o    = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        localparam int POS = data_pos(i);
        assign data_o[i] = rep_cw[POS-1];
    end
endmodule

// File: rtl/ecc_byte_pick.sv
// Splits a 32-bit word into byte lanes and selects one.
module ecc_byte_pick
    import ecc_rom_pkg::*;
(
    input  word_t                    word_i,
    input  logic [$clog2(LANES)-1:0] lane_i,
    output logic [LANE_W-1:0]        byte_o
);
    logic [LANE_W-1:0] lanes [LANES];

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign lanes[n] = word_i[n*LANE_W +: LANE_W];
    end

    assign byte_o = lanes[lane_i];
endmodule

// File: rtl/ecc_rom_fetch.sv
// Top: two-stage ECC ROM read. Stage 1 latches the physical row, slot and lane.
// Stage 2 unscatters, decodes, repairs, selects a byte and registers results.
// Assumes CW_AW > IL_AW and built-in defect locations inside the array.
module ecc_rom_fetch
    import ecc_rom_pkg::*;
#(
    parameter int CW_AW    = 6,
    parameter int IL_AW    = 2,
    parameter int PAIR_ROW = 3,
    parameter int PAIR_COL = 10,
    parameter int SGL_ROW  = 5,
    parameter int SGL_COL  = 0,
    parameter int DBL_ROW  = 7,
    parameter int DBL_SLOT = 2,
    localparam int ADDR_W  = CW_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              out_fixed,
    output logic              out_uncorr
);
    localparam int ROW_AW = CW_AW - IL_AW;
    localparam int SLOTS  = 1 << IL_AW;
    localparam int ROW_W  = CODE_W * SLOTS;

    logic [ROW_W-1:0] row_q;
    logic [IL_AW-1:0] slot_q;
    logic [1:0]       lane_q;
    logic             v1;
    code_t            cw_w;
    word_t            word_w;
    logic             fix_w;
    logic             unc_w;
    logic [7:0]       byte_w;

    ecc_rom_store #(
        .ROW_AW(ROW_AW), .SLOTS(SLOTS),
        .PAIR_ROW(PAIR_ROW), .PAIR_COL(PAIR_COL),
        .SGL_ROW(SGL_ROW), .SGL_COL(SGL_COL),
        .DBL_ROW(DBL_ROW), .DBL_SLOT(DBL_SLOT),
        .DBL_POS_A(7), .DBL_POS_B(32)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en),
        .row_i(rd_addr[ADDR_W-1 -: ROW_AW]), .row_o(row_q)
    );

    // Stage 1 side-band: which slot and lane the latched row serves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            slot_q <= '0;
            lane_q <= '0;
        end else begin
            v1 <= rd_en;
            if (rd_en) begin
                slot_q <= rd_addr[2 +: IL_AW];
                lane_q <= rd_addr[1:0];
            end
        end
    end

    ecc_cw_unscatter #(.SLOT_AW(IL_AW)) u_unscatter (
        .row_i(row_q), .slot_i(slot_q), .cw_o(cw_w)
    );

    ecc_hamming_fix u_fix (
        .cw_i(cw_w), .data_o(word_w), .fixed_o(fix_w), .uncorr_o(unc_w)
    );

    ecc_byte_pick u_pick (
        .word_i(word_w), .lane_i(lane_q), .byte_o(byte_w)
    );

    // Stage 2: register the result; byte holds and flags clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_byte   <= '0;
            out_fixed  <= 1'b0;
            out_uncorr <= 1'b0;
        end else begin
            out_valid  <= v1;
            out_fixed  <= v1 & fix_w;
            out_uncorr <= v1 & unc_w;
            if (v1) out_byte <= byte_w;
        end
    end

    // R1: each request yields a result two edges later
    p_read_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 out_valid);
    // R1: no request, no result
    p_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ##1 !out_valid);
    // R9: idle output byte is held
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_byte));
    // R9: flags only accompany a valid result
    p_idle_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_fixed && !out_uncorr));
    // R6: repaired and uncorrectable are never reported together
    p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_fixed && out_uncorr));
endmodule

// File: tb/sim_ecc_rom_fetch.sv
// Bench: behavioural reference with a two-deep expectation pipeline,
// compared at every falling edge.
module sim_ecc_rom_fetch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_fixed;
    logic       out_uncorr;

    ecc_rom_fetch #(
        .CW_AW(6), .IL_AW(2), .PAIR_ROW(3), .PAIR_COL(10),
        .SGL_ROW(5), .SGL_COL(0), .DBL_ROW(7), .DBL_SLOT(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .out_valid(out_valid), .out_byte(out_byte),
        .out_fixed(out_fixed), .out_uncorr(out_uncorr)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    bit    q_v [2];
    logic [7:0] q_b [2];
    bit    q_f [2];
    bit    q_u [2];
    string q_t [2];
    logic [7:0] held = '0;

    // Expected word after the read path (R3 fill, R8 defect effects).
    function automatic logic [31:0] ref_word(int w);
        logic [31:0] x;
        x = 32'(w + 1) * 32'h9E37_79B1;
        if (w == 30) x = x ^ 32'h0000_0008;   // R6: raw data bit 3 left inverted
        return x;
    endfunction

    // 0 clean, 1 repaired, 2 uncorrectable (R8 default defects).
    function automatic int ref_kind(int w);
        if (w == 14 || w == 15 || w == 20) return 1;
        if (w == 30) return 2;
        return 0;
    endfunction

    function automatic string ref_tag(int w);
        if (w == 14 || w == 15) return "R7 R8";
        if (w == 20) return "R5 R8";
        if (w == 30) return "R6 R8";
        return "R3 R4";
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_now();
        chk(out_valid == q_v[1], "R1", "out_valid", int'(out_valid), int'(q_v[1]));
        if (q_v[1]) begin
            chk(out_byte == q_b[1], q_t[1], "out_byte", int'(out_byte), int'(q_b[1]));
            chk(out_fixed == q_f[1], q_t[1], "out_fixed", int'(out_fixed), int'(q_f[1]));
            chk(out_uncorr == q_u[1], q_t[1], "out_uncorr", int'(out_uncorr), int'(q_u[1]));
            held = q_b[1];
        end else begin
            chk(out_byte == held, "R9", "idle out_byte", int'(out_byte), int'(held));
            chk(!out_fixed && !out_uncorr, "R9", "idle flags",
                int'({out_fixed, out_uncorr}), 0);
        end
    endtask

    task automatic step(bit en, int w, int lane);
        logic [31:0] word;
        @(negedge clk);
        compare_now();
        word   = ref_word(w);
        q_v[1] = q_v[0];  q_b[1] = q_b[0];  q_f[1] = q_f[0];
        q_u[1] = q_u[0];  q_t[1] = q_t[0];
        q_v[0] = en;
        q_b[0] = word[lane*8 +: 8];
        q_f[0] = (ref_kind(w) == 1);
        q_u[0] = (ref_kind(w) == 2);
        q_t[0] = ref_tag(w);
        rd_en   = en;
        rd_addr = {w[5:0], lane[1:0]};
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            q_v[i] = 1'b0; q_b[i] = '0; q_f[i] = 1'b0; q_u[i] = 1'b0; q_t[i] = "R9";
        end
        // R2: reset state, with a read request held during reset
        repeat (3) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        chk(!out_valid && out_byte == 8'h00 && !out_fixed && !out_uncorr, "R2",
            "reset outputs", int'({out_valid, out_byte, out_fixed, out_uncorr}), 0);
        rd_en = 1'b0;
        @(negedge clk);
        chk(!out_valid && out_byte == 8'h00, "R2", "reset hold",
            int'({out_valid, out_byte}), 0);
        rst_n = 1'b1;
        // R1 R3 R4: back-to-back sweep of every codeword and lane
        for (int w = 0; w < 64; w++)
            for (int l = 0; l < 4; l++) step(1'b1, w, l);
        repeat (3) step(1'b0, 0, 0);
        // R5 R6 R7: defect codewords with idle gaps between reads (R9)
        for (int l = 0; l < 4; l++) begin
            step(1'b1, 14, l); step(1'b0, 0, 0);
            step(1'b1, 15, l); step(1'b1, 20, l);
            step(1'b0, 0, 0); step(1'b0, 0, 0);
            step(1'b1, 30, l); step(1'b1, 13, l);
        end
        // R1 R9: mixed pattern of reads and idle cycles
        for (int i = 0; i < 300; i++)
            step((i % 3) != 0, (i * 37 + 5) % 64, (i * 7) % 4);
        repeat (3) step(1'b0, 0, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule